// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell

This block is one cell of a programmable-logic fabric. Five product terms come in from an AND-array that lies outside the block. Each term either adds to an OR sum or is taken away from the sum to act as a control line for the cell. The sum passes through a polarity XOR stage. The result then leaves the cell directly, or it goes into a single storage bit that acts as a D flip-flop or as a T flip-flop. The register has a selectable clock source: one of the global clocks in either polarity, or a product term. It also has an asynchronous set and an asynchronous reset, and each of these is taken from the global set/reset line or from a product term. An output enable comes with the cell output. The enable can be constant low, constant high, a product term, or one of the global enables in either polarity.

The whole fabric runs on one fast system clock `clk`. A selected cell clock acts on its rising transition. The block sees such a transition when the source was low at the previous `clk` edge and is high at the current one. Set and reset act at once on the output and also leave their value in the storage bit. Configuration is presented on static ports and is captured only on a `clk` edge where `cfg_load` is high.

A state machine sequences the cell through three states:
- BLANK: the cell holds its outputs low. It is entered on reset.
- PRELOAD: a single cycle in which the storage bit takes the configured initial value.
- ACTIVE: normal operation.

The transitions are:
- BLANK→PRELOAD: `cfg_load` is high.
- PRELOAD→ACTIVE: `cfg_load` is low.
- PRELOAD→PRELOAD: `cfg_load` is high again.
- ACTIVE→PRELOAD: a new `cfg_load` arrives while the cell is running.
- BLANK→BLANK and ACTIVE→ACTIVE: otherwise.

Top module: `mc_macrocell`

## Requirements
- R1: After `rst_n` is low, and until a configuration has been loaded, `mc_out` and `mc_oe` are both 0 whatever the other inputs do.
- R2: The configuration ports are captured only at a `clk` edge where `cfg_load`=1. In the cycle after that edge (PRELOAD) both outputs are 0, and the cell becomes ACTIVE at the following edge. A change on configuration ports without `cfg_load` has no effect on the outputs.
- R3: The data value is the OR of all product terms that are not taken for control, XORed with `cfg_xor_inv`. With `cfg_mode` 2'b00 or 2'b11 the cell is combinational, and in ACTIVE `mc_out` equals the data value in the same cycle.
- R4: Term k is taken out of the OR sum when any of these holds: `cfg_clk_sel`>=NGCK and `cfg_clk_idx`=k; `cfg_set_src`=2 and `cfg_set_idx`=k; `cfg_rst_src`=2 and `cfg_rst_idx`=k; `cfg_oe_mode`=2 and `cfg_oe_idx`=k. An index of NPT or above selects no term, and the control it feeds reads 0.
- R5: The cell clock is `gclk[i]` XOR `cfg_clk_inv` when `cfg_clk_sel`=i<NGCK, and `pterm[cfg_clk_idx]` otherwise. The register acts only at a `clk` edge where the selected clock is 1 and was 0 at the previous `clk` edge. The new value is visible right after that edge.
- R6: `cfg_mode`=2'b01 is a D register that captures the data value. `cfg_mode`=2'b10 is a T register that inverts its state when the data value is 1. In both modes `mc_out` shows the register.
- R7: Set and reset sources are encoded 0=none, 1=`gsr`, 2=`pterm[idx]`, 3=none. In a registered mode, an active reset forces `mc_out` to 0 and an active set forces it to 1 in the same cycle, with no clock needed. Reset wins when both are active. The forced value stays after the line is released.
- R8: In a registered mode, `mc_out` equals `cfg_preload` in the first ACTIVE cycle when no set, reset or clock transition is present.
- R9: `mc_oe` in ACTIVE is combinational and depends on `cfg_oe_mode`: 0 gives 0, 1 gives 1, 2 gives `pterm[cfg_oe_idx]`, 3 gives `goe[cfg_goe_idx]` XOR `cfg_goe_inv`.
- R10: A `cfg_load` while ACTIVE returns the cell to PRELOAD. Outputs are 0 for that cycle, and the register is reloaded from the new `cfg_preload`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pterm | input | NPT | Direct product terms |
| gclk | input | NGCK | Global clocks |
| gsr | input | 1 | Global set/reset |
| goe | input | NGOE | Global output enables |
| cfg_load | input | 1 | Configuration capture strobe |
| cfg_mode | input | 2 | 00 comb, 01 D, 10 T, 11 comb |
| cfg_xor_inv | input | 1 | Polarity of the XOR stage |
| cfg_preload | input | 1 | Initial register value |
| cfg_clk_sel | input | clog2(NGCK+1) | Global clock index, or product-term clock when >= NGCK |
| cfg_clk_inv | input | 1 | Inverts a selected global clock |
| cfg_clk_idx | input | clog2(NPT) | Term used as clock |
| cfg_set_src | input | 2 | Set source |
| cfg_set_idx | input | clog2(NPT) | Term used as set |
| cfg_rst_src | input | 2 | Reset source |
| cfg_rst_idx | input | clog2(NPT) | Term used as reset |
| cfg_oe_mode | input | 2 | Enable source |
| cfg_oe_idx | input | clog2(NPT) | Term used as enable |
| cfg_goe_idx | input | clog2(NGOE) | Global enable index |
| cfg_goe_inv | input | 1 | Inverts the global enable |
| mc_out | output | 1 | Cell output to interconnect and pin path |
| mc_oe | output | 1 | Output enable for the pin path |

## Verification
The data value, the term routing, the enable, and the forcing effect of set or reset are combinational. They are due in the same cycle as the stimulus. The storage bit changes one `clk` edge after a clock transition is seen. The preload value appears two edges after the load edge: the load edge leads to PRELOAD, and the next edge leads to ACTIVE. The bench drives every stimulus on a falling edge and lets one rising edge pass. It samples on the next falling edge, and it advances its arithmetic model of the register, the previous clock sample and the state at that same rising edge. This keeps combinational and registered expectations aligned.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        MODE_COMB  = 2'd0,
        MODE_D     = 2'd1,
        MODE_T     = 2'd2,
        MODE_SPARE = 2'd3
    } mc_mode_e;

    typedef enum logic [1:0] {
        CTL_NONE   = 2'd0,
        CTL_GLOBAL = 2'd1,
        CTL_TERM   = 2'd2,
        CTL_SPARE  = 2'd3
    } mc_ctl_e;

    typedef enum logic [1:0] {
        OE_LOW    = 2'd0,
        OE_HIGH   = 2'd1,
        OE_TERM   = 2'd2,
        OE_GLOBAL = 2'd3
    } mc_oe_e;

    typedef enum logic [1:0] {
        ST_BLANK   = 2'd0,
        ST_PRELOAD = 2'd1,
        ST_ACTIVE  = 2'd2
    } mc_state_e;

endpackage

// File: rtl/mc_term_route.sv
module mc_term_route
    import mc_pkg::*;
#(
    parameter int NPT = 5,
    parameter int PTW = 3
)(
    input  logic [NPT-1:0] pterm,
    input  logic           gsr,
    input  logic           clk_from_term,
    input  logic [PTW-1:0] clk_idx,
    input  mc_ctl_e        set_src,
    input  logic [PTW-1:0] set_idx,
    input  mc_ctl_e        rst_src,
    input  logic [PTW-1:0] rst_idx,
    input  logic           oe_from_term,
    input  logic [PTW-1:0] oe_idx,
    output logic           sum,
    output logic           pt_clk,
    output logic           set_act,
    output logic           rst_act,
    output logic           pt_oe
);

    logic [NPT-1:0] hit_clk;
    logic [NPT-1:0] hit_set;
    logic [NPT-1:0] hit_rst;
    logic [NPT-1:0] hit_oe;
    logic [NPT-1:0] steal;

    // One decoder slice per term: a term claimed by any control leaves the sum (R4)
    for (genvar gi = 0; gi < NPT; gi++) begin : g_term
        assign hit_clk[gi] = clk_from_term && (clk_idx == PTW'(gi));
        assign hit_set[gi] = (set_src == CTL_TERM) && (set_idx == PTW'(gi));
        assign hit_rst[gi] = (rst_src == CTL_TERM) && (rst_idx == PTW'(gi));
        assign hit_oe[gi]  = oe_from_term && (oe_idx == PTW'(gi));
        assign steal[gi]   = hit_clk[gi] | hit_set[gi] | hit_rst[gi] | hit_oe[gi];
    end

    assign sum    = |(pterm & ~steal);
    assign pt_clk = |(pterm & hit_clk);
    assign pt_oe  = |(pterm & hit_oe);

    always_comb begin
        unique case (set_src)
            CTL_NONE:   set_act = 1'b0;
            CTL_GLOBAL: set_act = gsr;
            CTL_TERM:   set_act = |(pterm & hit_set);
            CTL_SPARE:  set_act = 1'b0;
        endcase
        unique case (rst_src)
            CTL_NONE:   rst_act = 1'b0;
            CTL_GLOBAL: rst_act = gsr;
            CTL_TERM:   rst_act = |(pterm & hit_rst);
            CTL_SPARE:  rst_act = 1'b0;
        endcase
    end

endmodule

// File: rtl/mc_clk_edge.sv
module mc_clk_edge #(
    parameter int NGCK = 3,
    parameter int CSW  = 2
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGCK-1:0] gclk,
    input  logic [CSW-1:0]  ck_sel,
    input  logic            ck_inv,
    input  logic            pt_clk,
    output logic            fire
);

    logic src;
    logic prev_q;

    always_comb begin
        src = pt_clk;
        for (int i = 0; i < NGCK; i++) begin
            if (ck_sel == CSW'(i)) src = gclk[i] ^ ck_inv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src;
    end

    assign fire = src & ~prev_q;

    // R5: a detected transition needs a low sample first, so two cannot be adjacent
    assert_single_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/mc_oe_sel.sv
module mc_oe_sel
    import mc_pkg::*;
#(
    parameter int NGOE = 4,
    parameter int GW   = 2
)(
    input  mc_oe_e          oe_mode,
    input  logic            pt_oe,
    input  logic [NGOE-1:0] goe,
    input  logic [GW-1:0]   goe_idx,
    input  logic            goe_inv,
    input  logic            active,
    output logic            oe
);

    logic gsel;
    logic raw;

    always_comb begin
        gsel = 1'b0;
        for (int i = 0; i < NGOE; i++) begin
            if (goe_idx == GW'(i)) gsel = goe[i];
        end
        unique case (oe_mode)
            OE_LOW:    raw = 1'b0;
            OE_HIGH:   raw = 1'b1;
            OE_TERM:   raw = pt_oe;
            OE_GLOBAL: raw = gsel ^ goe_inv;
        endcase
        oe = active & raw;
    end

endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_load,
    input  mc_mode_e mode,
    input  logic     preload,
    input  logic     d,
    input  logic     fire,
    input  logic     set_act,
    input  logic     rst_act,
    output logic     q_vis,
    output logic     active
);

    mc_state_e state_q;
    mc_state_e state_d;
    logic      q_r;
    logic      regd;

    assign regd = (mode == MODE_D) || (mode == MODE_T);

    always_comb begin
        unique case (state_q)
            ST_BLANK:   state_d = cfg_load ? ST_PRELOAD : ST_BLANK;
            ST_PRELOAD: state_d = cfg_load ? ST_PRELOAD : ST_ACTIVE;
            ST_ACTIVE:  state_d = cfg_load ? ST_PRELOAD : ST_ACTIVE;
            default:    state_d = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= 1'b0;
        end else begin
            unique case (state_q)
                ST_PRELOAD: q_r <= preload;
                ST_ACTIVE: begin
                    if (regd) begin
                        if (rst_act)      q_r <= 1'b0;
                        else if (set_act) q_r <= 1'b1;
                        else if (fire)    q_r <= (mode == MODE_T) ? (q_r ^ d) : d;
                    end
                end
                default: q_r <= q_r;
            endcase
        end
    end

    always_comb begin
        active = (state_q == ST_ACTIVE);
        if (rst_act)      q_vis = 1'b0;
        else if (set_act) q_vis = 1'b1;
        else              q_vis = q_r;
    end

    assert_blank_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK && !cfg_load) |=> (state_q == ST_BLANK));

    assert_load_enters_preload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (state_q == ST_PRELOAD));

    assert_preload_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRELOAD) |=> (q_r == $past(preload)));

    assert_reset_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && regd && rst_act) |=> (q_r == 1'b0));

    assert_set_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && regd && set_act && !rst_act) |=> (q_r == 1'b1));

    assert_d_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && mode == MODE_D && fire && !set_act && !rst_act)
        |=> (q_r == $past(d)));

    assert_no_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !fire && !set_act && !rst_act) |=> $stable(q_r));

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
    import mc_pkg::*;
#(
    parameter int NPT  = 5,
    parameter int NGCK = 3,
    parameter int NGOE = 4,
    localparam int PTW = (NPT > 1) ? $clog2(NPT) : 1,
    localparam int CSW = $clog2(NGCK + 1),
    localparam int GW  = (NGOE > 1) ? $clog2(NGOE) : 1
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPT-1:0]  pterm,
    input  logic [NGCK-1:0] gclk,
    input  logic            gsr,
    input  logic [NGOE-1:0] goe,
    input  logic            cfg_load,
    input  logic [1:0]      cfg_mode,
    input  logic            cfg_xor_inv,
    input  logic            cfg_preload,
    input  logic [CSW-1:0]  cfg_clk_sel,
    input  logic            cfg_clk_inv,
    input  logic [PTW-1:0]  cfg_clk_idx,
    input  logic [1:0]      cfg_set_src,
    input  logic [PTW-1:0]  cfg_set_idx,
    input  logic [1:0]      cfg_rst_src,
    input  logic [PTW-1:0]  cfg_rst_idx,
    input  logic [1:0]      cfg_oe_mode,
    input  logic [PTW-1:0]  cfg_oe_idx,
    input  logic [GW-1:0]   cfg_goe_idx,
    input  logic            cfg_goe_inv,
    output logic            mc_out,
    output logic            mc_oe
);

    mc_mode_e       mode_r;
    logic           xinv_r;
    logic           pre_r;
    logic [CSW-1:0] csel_r;
    logic           cinv_r;
    logic [PTW-1:0] cidx_r;
    mc_ctl_e        ssrc_r;
    logic [PTW-1:0] sidx_r;
    mc_ctl_e        rsrc_r;
    logic [PTW-1:0] ridx_r;
    mc_oe_e         oem_r;
    logic [PTW-1:0] oidx_r;
    logic [GW-1:0]  gidx_r;
    logic           ginv_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r <= MODE_COMB;
            xinv_r <= 1'b0;
            pre_r  <= 1'b0;
            csel_r <= '0;
            cinv_r <= 1'b0;
            cidx_r <= '0;
            ssrc_r <= CTL_NONE;
            sidx_r <= '0;
            rsrc_r <= CTL_NONE;
            ridx_r <= '0;
            oem_r  <= OE_LOW;
            oidx_r <= '0;
            gidx_r <= '0;
            ginv_r <= 1'b0;
        end else if (cfg_load) begin
            mode_r <= mc_mode_e'(cfg_mode);
            xinv_r <= cfg_xor_inv;
            pre_r  <= cfg_preload;
            csel_r <= cfg_clk_sel;
            cinv_r <= cfg_clk_inv;
            cidx_r <= cfg_clk_idx;
            ssrc_r <= mc_ctl_e'(cfg_set_src);
            sidx_r <= cfg_set_idx;
            rsrc_r <= mc_ctl_e'(cfg_rst_src);
            ridx_r <= cfg_rst_idx;
            oem_r  <= mc_oe_e'(cfg_oe_mode);
            oidx_r <= cfg_oe_idx;
            gidx_r <= cfg_goe_idx;
            ginv_r <= cfg_goe_inv;
        end
    end

    logic clk_from_term;
    logic sum, pt_clk, set_act, rst_act, pt_oe;
    logic fire, q_vis, active, d_val, regd;

    assign clk_from_term = (int'(csel_r) >= NGCK);

    mc_term_route #(.NPT(NPT), .PTW(PTW)) u_route (
        .pterm         (pterm),
        .gsr           (gsr),
        .clk_from_term (clk_from_term),
        .clk_idx       (cidx_r),
        .set_src       (ssrc_r),
        .set_idx       (sidx_r),
        .rst_src       (rsrc_r),
        .rst_idx       (ridx_r),
        .oe_from_term  (oem_r == OE_TERM),
        .oe_idx        (oidx_r),
        .sum           (sum),
        .pt_clk        (pt_clk),
        .set_act       (set_act),
        .rst_act       (rst_act),
        .pt_oe         (pt_oe)
    );

    mc_clk_edge #(.NGCK(NGCK), .CSW(CSW)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .gclk   (gclk),
        .ck_sel (csel_r),
        .ck_inv (cinv_r),
        .pt_clk (pt_clk),
        .fire   (fire)
    );

    assign d_val = sum ^ xinv_r;
    assign regd  = (mode_r == MODE_D) || (mode_r == MODE_T);

    mc_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .mode     (mode_r),
        .preload  (pre_r),
        .d        (d_val),
        .fire     (fire),
        .set_act  (set_act),
        .rst_act  (rst_act),
        .q_vis    (q_vis),
        .active   (active)
    );

    mc_oe_sel #(.NGOE(NGOE), .GW(GW)) u_oe (
        .oe_mode (oem_r),
        .pt_oe   (pt_oe),
        .goe     (goe),
        .goe_idx (gidx_r),
        .goe_inv (ginv_r),
        .active  (active),
        .oe      (mc_oe)
    );

    assign mc_out = active ? (regd ? q_vis : d_val) : 1'b0;

    // R10: the cycle after any load shows nothing on either output
    assert_reload_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (!mc_out && !mc_oe));

endmodule

// File: tb/mc_macrocell_tb.sv
`timescale 1ns/1ps
module mc_macrocell_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [4:0] pt = '0;
    logic [2:0] gk = '0;
    logic       gs = 1'b0;
    logic [3:0] ge = '0;
    logic       ld = 1'b0;

    logic [1:0] i_mode = '0, i_ssrc = '0, i_rsrc = '0, i_oem = '0, i_csel = '0, i_gidx = '0;
    logic       i_inv = 0, i_pre = 0, i_cinv = 0, i_ginv = 0;
    logic [2:0] i_cidx = '0, i_sidx = '0, i_ridx = '0, i_oidx = '0;

    logic [1:0] b_mode = '0, b_ssrc = '0, b_rsrc = '0, b_oem = '0, b_csel = '0, b_gidx = '0;
    logic       b_inv = 0, b_pre = 0, b_cinv = 0, b_ginv = 0;
    logic [2:0] b_cidx = '0, b_sidx = '0, b_ridx = '0, b_oidx = '0;

    int   checks = 0;
    int   fails  = 0;
    int   st_m   = 0;
    logic q_m    = 1'b0;
    logic prev_m = 1'b0;
    logic [15:0] lf = 16'hACE1;

    logic mc_out, mc_oe;

    mc_macrocell u_dut (
        .clk(clk), .rst_n(rst_n), .pterm(pt), .gclk(gk), .gsr(gs), .goe(ge),
        .cfg_load(ld), .cfg_mode(i_mode), .cfg_xor_inv(i_inv), .cfg_preload(i_pre),
        .cfg_clk_sel(i_csel), .cfg_clk_inv(i_cinv), .cfg_clk_idx(i_cidx),
        .cfg_set_src(i_ssrc), .cfg_set_idx(i_sidx), .cfg_rst_src(i_rsrc), .cfg_rst_idx(i_ridx),
        .cfg_oe_mode(i_oem), .cfg_oe_idx(i_oidx), .cfg_goe_idx(i_gidx), .cfg_goe_inv(i_ginv),
        .mc_out(mc_out), .mc_oe(mc_oe)
    );

    function automatic logic pick(input logic [2:0] ix);
        logic r = 1'b0;
        for (int k = 0; k < 5; k++) if (ix == 3'(k)) r = pt[k];
        return r;
    endfunction

    function automatic logic [4:0] steal_m();
        logic [4:0] s;
        for (int k = 0; k < 5; k++)
            s[k] = ((b_csel >= 2'd3) && (b_cidx == 3'(k))) ||
                   ((b_ssrc == 2'd2) && (b_sidx == 3'(k))) ||
                   ((b_rsrc == 2'd2) && (b_ridx == 3'(k))) ||
                   ((b_oem  == 2'd2) && (b_oidx == 3'(k)));
        return s;
    endfunction

    function automatic logic d_m();
        return (|(pt & ~steal_m())) ^ b_inv;
    endfunction

    function automatic logic ck_m();
        if (b_csel < 2'd3) return gk[b_csel] ^ b_cinv;
        return pick(b_cidx);
    endfunction

    function automatic logic ctl_m(input logic [1:0] src, input logic [2:0] ix);
        if (src == 2'd1) return gs;
        if (src == 2'd2) return pick(ix);
        return 1'b0;
    endfunction

    function automatic logic regd_m();
        return (b_mode == 2'd1) || (b_mode == 2'd2);
    endfunction

    function automatic logic exp_out();
        if (st_m != 2) return 1'b0;
        if (!regd_m()) return d_m();
        if (ctl_m(b_rsrc, b_ridx)) return 1'b0;
        if (ctl_m(b_ssrc, b_sidx)) return 1'b1;
        return q_m;
    endfunction

    function automatic logic exp_oe();
        if (st_m != 2) return 1'b0;
        case (b_oem)
            2'd0: return 1'b0;
            2'd1: return 1'b1;
            2'd2: return pick(b_oidx);
            default: return ge[b_gidx] ^ b_ginv;
        endcase
    endfunction

    task automatic chk(input logic a, input logic e, input string tag, input string what);
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, a, e, $time);
        end
    endtask

    // Advances the reference model across one rising clk edge
    task automatic tick();
        logic ck, d, s, r;
        ck = ck_m(); d = d_m();
        s = ctl_m(b_ssrc, b_sidx); r = ctl_m(b_rsrc, b_ridx);
        @(posedge clk);
        if (st_m == 2 && regd_m()) begin
            if (r)                 q_m = 1'b0;
            else if (s)            q_m = 1'b1;
            else if (ck && !prev_m) q_m = (b_mode == 2'd2) ? (q_m ^ d) : d;
        end else if (st_m == 1) begin
            q_m = b_pre;
        end
        prev_m = ck;
        if (ld) begin
            b_mode = i_mode; b_inv = i_inv; b_pre = i_pre; b_csel = i_csel; b_cinv = i_cinv;
            b_cidx = i_cidx; b_ssrc = i_ssrc; b_sidx = i_sidx; b_rsrc = i_rsrc; b_ridx = i_ridx;
            b_oem = i_oem; b_oidx = i_oidx; b_gidx = i_gidx; b_ginv = i_ginv;
            st_m = 1;
        end else if (st_m == 1) begin
            st_m = 2;
        end
    endtask

    task automatic step(input logic [4:0] p, input logic [2:0] g, input logic s,
                        input logic [3:0] e, input string tag);
        pt = p; gk = g; gs = s; ge = e;
        tick();
        @(negedge clk);
        chk(mc_out, exp_out(), tag, "mc_out");
        chk(mc_oe,  exp_oe(),  tag, "mc_oe");
    endtask

    task automatic cfgr(input logic [1:0] mode, input logic inv, input logic pre,
                        input logic [1:0] csel, input logic cinv, input logic [2:0] cidx,
                        input logic [1:0] ssrc, input logic [2:0] sidx,
                        input logic [1:0] rsrc, input logic [2:0] ridx,
                        input logic [1:0] oem, input logic [2:0] oidx,
                        input logic [1:0] gidx, input logic ginv,
                        input string tag_load, input string tag_act);
        pt = '0; gk = '0; gs = 1'b0;
        i_mode = mode; i_inv = inv; i_pre = pre; i_csel = csel; i_cinv = cinv; i_cidx = cidx;
        i_ssrc = ssrc; i_sidx = sidx; i_rsrc = rsrc; i_ridx = ridx;
        i_oem = oem; i_oidx = oidx; i_gidx = gidx; i_ginv = ginv;
        ld = 1'b1;
        tick();
        @(negedge clk);
        ld = 1'b0;
        chk(mc_out, 1'b0, tag_load, "mc_out in preload cycle");
        chk(mc_oe,  1'b0, tag_load, "mc_oe in preload cycle");
        tick();
        @(negedge clk);
        chk(mc_out, exp_out(), tag_act, "mc_out first active");
        chk(mc_oe,  exp_oe(),  tag_act, "mc_oe first active");
    endtask

    task automatic adv();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mc_out, 1'b0, "R1", "mc_out in reset");
        chk(mc_oe,  1'b0, "R1", "mc_oe in reset");
        rst_n = 1'b1;
        step(5'h1F, 3'h7, 1'b1, 4'hF, "R1");
        step(5'h0A, 3'h2, 1'b0, 4'h5, "R1");

        // R3: combinational sum, both polarities and the spare mode code
        cfgr(2'd0, 0, 0, 2'd0, 0, 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 2'd1, 3'd0, 2'd0, 0, "R2", "R3");
        for (int p = 0; p < 32; p++) step(5'(p), 3'd0, 1'b0, 4'd0, "R3");
        cfgr(2'd3, 1, 0, 2'd0, 0, 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 2'd1, 3'd0, 2'd0, 0, "R10", "R3");
        for (int p = 0; p < 32; p++) step(5'(p), 3'd0, 1'b0, 4'd0, "R3");

        // R4: stealing by enable, set, reset, clock; out-of-range index steals nothing
        for (int k = 0; k < 5; k++) begin
            cfgr(2'd0, 0, 0, 2'd0, 0, 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 2'd2, 3'(k), 2'd0, 0, "R10", "R4");
            for (int p = 0; p < 32; p++) step(5'(p), 3'd0, 1'b0, 4'd0, "R4");
        end
        for (int k = 0; k < 5; k++) begin
            cfgr(2'd0, 0, 0, 2'd0, 0, 3'd0, 2'd2, 3'(k), 2'd2, 3'((k + 2) % 5), 2'd1, 3'd0, 2'd0, 0, "R10", "R4");
            for (int p = 0; p < 32; p++) step(5'(p), 3'd0, 1'b0, 4'd0, "R4");
        end
        cfgr(2'd0, 1, 0, 2'd3, 0, 3'd2, 2'd0, 3'd0, 2'd0, 3'd0, 2'd2, 3'd6, 2'd0, 0, "R10", "R4");
        for (int p = 0; p < 32; p++) step(5'(p), 3'd0, 1'b0, 4'd0, "R4");

        // R9: enable from each global line in both polarities, and constant low
        for (int gi = 0; gi < 4; gi++) begin
            for (int gv = 0; gv < 2; gv++) begin
                cfgr(2'd0, 0, 0, 2'd0, 0, 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 2'd3, 3'd0, 2'(gi), 1'(gv), "R10", "R9");
                for (int e = 0; e < 16; e++) step(5'd1, 3'd0, 1'b0, 4'(e), "R9");
            end
        end
        cfgr(2'd0, 0, 0, 2'd0, 0, 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 2'd0, 0, "R10", "R9");
        for (int e = 0; e < 16; e++) step(5'(e), 3'd0, 1'b0, 4'(e), "R9");

        // R5/R6: D register on each global clock in both polarities, then T register
        for (int c = 0; c < 3; c++) begin
            for (int v = 0; v < 2; v++) begin
                cfgr(2'd1, 0, 0, 2'(c), 1'(v), 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 2'd1, 3'd0, 2'd0, 0, "R10", "R5");
                for (int n = 0; n < 40; n++) begin adv(); step(lf[4:0], lf[7:5], 1'b0, 4'd0, "R5"); end
            end
            cfgr(2'd2, 0, 0, 2'(c), 0, 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 2'd1, 3'd0, 2'd0, 0, "R10", "R6");
            for (int n = 0; n < 40; n++) begin adv(); step(lf[4:0], lf[7:5], 1'b0, 4'd0, "R6"); end
        end
        cfgr(2'd1, 1, 0, 2'd3, 0, 3'd4, 2'd0, 3'd0, 2'd0, 3'd0, 2'd1, 3'd0, 2'd0, 0, "R10", "R5");
        for (int n = 0; n < 40; n++) begin adv(); step(lf[4:0], lf[7:5], 1'b0, 4'd0, "R5"); end
        cfgr(2'd2, 0, 1, 2'd3, 0, 3'd1, 2'd0, 3'd0, 2'd0, 3'd0, 2'd1, 3'd0, 2'd0, 0, "R10", "R6");
        for (int n = 0; n < 40; n++) begin adv(); step(lf[4:0], lf[7:5], 1'b0, 4'd0, "R6"); end

        // R7: set from term 0, reset from the global line; reset wins and values persist
        cfgr(2'd1, 0, 0, 2'd0, 0, 3'd0, 2'd2, 3'd0, 2'd1, 3'd0, 2'd1, 3'd0, 2'd0, 0, "R10", "R7");
        step(5'b00001, 3'd0, 1'b0, 4'd0, "R7");
        chk(mc_out, 1'b1, "R7", "set alone forces 1");
        step(5'b00000, 3'd0, 1'b0, 4'd0, "R7");
        chk(mc_out, 1'b1, "R7", "set value retained");
        step(5'b00001, 3'd0, 1'b1, 4'd0, "R7");
        chk(mc_out, 1'b0, "R7", "reset wins over set");
        step(5'b00000, 3'd0, 1'b0, 4'd0, "R7");
        chk(mc_out, 1'b0, "R7", "reset value retained");
        for (int n = 0; n < 40; n++) begin adv(); step(lf[4:0], lf[7:5], lf[8] & lf[9], 4'd0, "R7"); end
        cfgr(2'd2, 0, 0, 2'd3, 0, 3'd3, 2'd1, 3'd0, 2'd2, 3'd1, 2'd1, 3'd0, 2'd0, 0, "R10", "R7");
        for (int n = 0; n < 40; n++) begin adv(); step(lf[4:0], lf[7:5], lf[8] & lf[9], 4'd0, "R7"); end

        // R8: preload value shown before any clock transition
        cfgr(2'd1, 0, 1, 2'd0, 0, 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 2'd1, 3'd0, 2'd0, 0, "R10", "R8");
        chk(mc_out, 1'b1, "R8", "preload 1");
        cfgr(2'd2, 0, 0, 2'd0, 0, 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 2'd1, 3'd0, 2'd0, 0, "R10", "R8");
        chk(mc_out, 1'b0, "R8", "preload 0");
        cfgr(2'd1, 0, 1, 2'd1, 1, 3'd0, 2'd0, 3'd0, 2'd0, 3'd0, 2'd1, 3'd0, 2'd0, 0, "R10", "R8");
        chk(mc_out, 1'b1, "R8", "preload 1 with inverted clock");

        // R2: configuration ports move without the strobe; behaviour must not change
        i_mode = 2'd0; i_inv = 1'b1; i_oem = 2'd0; i_csel = 2'd3; i_ssrc = 2'd1; i_rsrc = 2'd1;
        for (int n = 0; n < 30; n++) begin adv(); step(lf[4:0], lf[7:5], lf[8], lf[12:9], "R2"); end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule